// File: doc/BRIEF.md
# AES-256 Iterative Block Cipher Core

This core encrypts or decrypts one 128-bit block under a 256-bit key, one round per clock. A key is first presented with a one-cycle load strobe. The core then expands it into the full round-key schedule and keeps it in on-chip storage. After that, any number of blocks can be processed under that key. A block is launched with a start pulse. The `decrypt` input chooses the direction for that block. A one-cycle `done` pulse marks the result.

A single sixteen-lane S-box bank serves both the round datapath and the key schedule. During expansion, lanes 0 to 3 compute the key-schedule substitution of one word per cycle. During a round, all sixteen lanes run in forward or inverse mode. One round counter drives both directions. Encryption takes round keys in ascending order and decryption in descending order.

The control state machine has four states. S_NOKEY is the state after reset, with no key loaded. S_EXPAND builds the schedule. S_READY waits for work. S_ROUND runs the rounds. Its transitions are:
- T_LOAD: S_NOKEY or S_READY to S_EXPAND, on `key_load`.
- T_KEYED: S_EXPAND to S_READY, when the last schedule word is written.
- T_LAUNCH: S_READY to S_ROUND, on `start` when `key_load` is low.
- T_FINISH: S_ROUND to S_READY, after round 14.

Top module: `aes256_core`

## Requirements
- R1: With key 000102…1f (bytes ascending) and plaintext 00112233445566778899aabbccddeeff, encryption (`decrypt`=0) gives 8ea2b7ca516745bfeafc49904b496089. With the all-zero key and the all-zero block it gives dc95c078a2408989ad48a21492842087. The most significant byte of every bus is byte 0.
- R2: With the same keys, decryption (`decrypt`=1) of each of those ciphertexts gives back the matching plaintext.
- R3: For any block, decrypting the encryption result under the same key gives back the original block.
- R4: `done` is high for exactly one cycle, 14 clock edges after the edge that accepts `start`. `block_out` holds that result until the next accepted start. `busy` is high from the edge after acceptance until `done` rises.
- R5: `start` has no effect in S_NOKEY or S_EXPAND. No `busy` is raised and no `done` follows.
- R6: After a `key_load` is accepted, `key_ready` stays low for 51 edges and rises on the 52nd, one edge per schedule word beyond the first eight.
- R7: `start` asserted while `busy` is high is ignored. The block in flight completes unchanged, and only one `done` follows.
- R8: After reset, `key_ready`, `busy` and `done` are 0 and `block_out` is all zeros.
- R9: A new `key_load` in S_READY replaces the schedule. Later blocks use the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Strobe: capture `key_in` and start expansion |
| key_in | input | 256 | Cipher key, first word in bits 255:224 |
| start | input | 1 | Launch one block |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt; sampled with `start` |
| block_in | input | 128 | Input block, sampled with `start` |
| key_ready | output | 1 | Schedule complete, core idle |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle result strobe |
| block_out | output | 128 | Result, valid from `done` until the next launch |

## Verification
The result of a block is due exactly 14 edges after the launch edge. The driver counts falling edges after launch and requires `done` low on the first 13 and high on the 14th. `key_ready` is due on the 52nd edge after a load, and the driver checks that edge and the one before it. Expected results go into a scoreboard queue at launch. A monitor compares them on each `done` and flags any `done` with no entry waiting, which is how ignored starts are caught.

// File: rtl/aescore_pkg.sv
package aescore_pkg;

    typedef enum logic [1:0] {
        S_NOKEY  = 2'd0,
        S_EXPAND = 2'd1,
        S_READY  = 2'd2,
        S_ROUND  = 2'd3
    } core_state_t;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xt(t);
        end
        return acc;
    endfunction

    // x^254: multiplicative inverse, maps 0 to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] p = x;
        logic [7:0] r = 8'h01;
        for (int k = 1; k < 8; k++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        logic [15:0] d;
        d = {b, b} << n;
        return d[15:8];
    endfunction

    function automatic logic [7:0] sub_fwd(input logic [7:0] x);
        logic [7:0] y;
        y = gf_inv(x);
        return y ^ rotl8(y, 1) ^ rotl8(y, 2) ^ rotl8(y, 3) ^ rotl8(y, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sub_inv(input logic [7:0] x);
        logic [7:0] y;
        y = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
        return gf_inv(y);
    endfunction

endpackage

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane (
    input  logic       inv,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    import aescore_pkg::*;

    always_comb begin
        dout = inv ? sub_inv(din) : sub_fwd(din);
    end

    always_comb begin
        AST_SBOX_ENDS: assert (inv || din != 8'h00 || dout == 8'h63); // R1
    end
endmodule

// File: rtl/aes_round_lin.sv
module aes_round_lin (
    input  logic         inv,
    input  logic         last,
    input  logic [127:0] sub,
    input  logic [127:0] rkey,
    output logic [127:0] dout
);
    import aescore_pkg::*;

    logic [7:0] sb  [16];
    logic [7:0] sh  [16];
    logic [7:0] pre [16];
    logic [7:0] mx  [16];
    logic [7:0] kc  [4];

    always_comb begin
        for (int i = 0; i < 16; i++) sb[i] = sub[127-8*i -: 8];
        // row permutation: left rotation forward, right rotation inverse
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                if (inv) sh[4*c+r] = sb[4*((c - r + 4) % 4) + r];
                else     sh[4*c+r] = sb[4*((c + r) % 4) + r];
            end
        end
        // inverse path injects the key before column mixing
        for (int i = 0; i < 16; i++) begin
            pre[i] = inv ? (sh[i] ^ rkey[127-8*i -: 8]) : sh[i];
        end
        if (inv) begin
            kc[0] = 8'h0e; kc[1] = 8'h0b; kc[2] = 8'h0d; kc[3] = 8'h09;
        end else begin
            kc[0] = 8'h02; kc[1] = 8'h03; kc[2] = 8'h01; kc[3] = 8'h01;
        end
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                mx[4*c+r] = 8'h00;
                for (int j = 0; j < 4; j++) begin
                    mx[4*c+r] = mx[4*c+r] ^ gf_mul(pre[4*c+j], kc[(j - r + 4) % 4]);
                end
            end
        end
        for (int i = 0; i < 16; i++) begin
            if (inv) dout[127-8*i -: 8] = last ? pre[i] : mx[i];
            else     dout[127-8*i -: 8] = (last ? pre[i] : mx[i]) ^ rkey[127-8*i -: 8];
        end
    end
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched #(
    parameter int NK = 8,
    parameter int NR = NK + 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [32*NK-1:0]      key,
    input  logic [31:0]           sub_out,
    input  logic [$clog2(NR+1)-1:0] rk_idx,
    output logic [31:0]           sub_in,
    output logic                  busy,
    output logic                  last,
    output logic [127:0]          rkey
);
    import aescore_pkg::*;

    localparam int NW = 4 * (NR + 1);
    localparam int IW = $clog2(NW + 1);

    logic [31:0]   words [NW];
    logic [IW-1:0] idx;
    logic [7:0]    rcon;
    logic          busy_q;
    logic [31:0]   prev, far, nxt;
    logic [IW-1:0] base;
    int            phase;

    assign prev  = words[idx - IW'(1)];
    assign far   = words[idx - IW'(NK)];
    assign phase = int'(idx) % NK;
    assign busy  = busy_q;
    assign last  = busy_q && (int'(idx) == NW - 1);

    always_comb begin
        sub_in = (phase == 0) ? {prev[23:0], prev[31:24]} : prev;
        if (phase == 0)               nxt = far ^ sub_out ^ {rcon, 24'h000000};
        else if (NK > 6 && phase == 4) nxt = far ^ sub_out;
        else                          nxt = far ^ prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= IW'(NK);
            rcon   <= 8'h01;
            busy_q <= 1'b0;
        end else if (load) begin
            for (int k = 0; k < NK; k++) words[k] <= key[32*(NK-k)-1 -: 32];
            idx    <= IW'(NK);
            rcon   <= 8'h01;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            words[idx] <= nxt;
            idx        <= idx + IW'(1);
            if (phase == 0) rcon <= gf_xt(rcon);
            if (int'(idx) == NW - 1) busy_q <= 1'b0;
        end
    end

    assign base = IW'({rk_idx, 2'b00});
    assign rkey = {words[base], words[base + IW'(1)], words[base + IW'(2)], words[base + IW'(3)]};

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (int'(idx) >= NK && int'(idx) < NW)); // R6
    AST_SCHED_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !busy_q); // R6
endmodule

// File: rtl/aes256_core.sv
module aes256_core #(
    parameter int NK = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_load,
    input  logic [255:0] key_in,
    input  logic         start,
    input  logic         decrypt,
    input  logic [127:0] block_in,
    output logic         key_ready,
    output logic         busy,
    output logic         done,
    output logic [127:0] block_out
);
    import aescore_pkg::*;

    localparam int NR = NK + 6;
    localparam int RW = $clog2(NR + 1);

    core_state_t   st, st_nx;
    logic [RW-1:0] rnd;
    logic          mode_q;
    logic [127:0]  blk_q;
    logic          done_q;

    logic          load_ok, start_ok;
    logic          kx_busy, kx_last;
    logic [31:0]   kx_sub_in;
    logic [RW-1:0] rk_idx;
    logic [127:0]  rkey, bank_in, bank_out, round_out;
    logic          bank_inv;

    assign load_ok  = key_load && (st == S_NOKEY || st == S_READY);
    assign start_ok = start && (st == S_READY) && !key_load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_NOKEY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_NOKEY:  if (load_ok) st_nx = S_EXPAND;
            S_EXPAND: if (kx_last) st_nx = S_READY;
            S_READY: begin
                if (load_ok)       st_nx = S_EXPAND;
                else if (start_ok) st_nx = S_ROUND;
            end
            S_ROUND:  if (int'(rnd) == NR) st_nx = S_READY;
        endcase
    end

    // shared substitution bank: key words in lanes 0..3 outside of rounds
    assign bank_inv = (st == S_ROUND) && mode_q;
    assign bank_in  = (st == S_ROUND) ? blk_q : {kx_sub_in, 96'h0};

    for (genvar g = 0; g < 16; g++) begin : g_bank
        aes_sbox_lane u_lane (
            .inv  (bank_inv),
            .din  (bank_in[127-8*g -: 8]),
            .dout (bank_out[127-8*g -: 8])
        );
    end

    always_comb begin
        if (st == S_ROUND) rk_idx = mode_q ? (RW'(NR) - rnd) : rnd;
        else               rk_idx = decrypt ? RW'(NR) : RW'(0);
    end

    aes_key_sched #(.NK(NK), .NR(NR)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_ok),
        .key     (key_in),
        .sub_out (bank_out[127:96]),
        .rk_idx  (rk_idx),
        .sub_in  (kx_sub_in),
        .busy    (kx_busy),
        .last    (kx_last),
        .rkey    (rkey)
    );

    aes_round_lin u_round (
        .inv  (mode_q),
        .last (int'(rnd) == NR),
        .sub  (bank_out),
        .rkey (rkey),
        .dout (round_out)
    );

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd    <= '0;
            mode_q <= 1'b0;
            blk_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st == S_ROUND) && (int'(rnd) == NR);
            if (start_ok) begin
                blk_q  <= block_in ^ rkey;
                mode_q <= decrypt;
                rnd    <= RW'(1);
            end else if (st == S_ROUND) begin
                blk_q <= round_out;
                rnd   <= rnd + RW'(1);
            end
        end
    end

    assign key_ready = (st == S_READY);
    assign busy      = (st == S_ROUND);
    assign done      = done_q;
    assign block_out = blk_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == S_ROUND && !busy)); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_ROUND && !start_ok) |=> $stable(block_out)); // R4
    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXPAND || st == S_NOKEY) |=> st != S_ROUND); // R5
    AST_SCHED_IDLE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !kx_busy); // R7
    AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd >= RW'(1) && int'(rnd) <= NR)); // R7
endmodule

// File: tb/aes256_core_test.sv
module aes256_core_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [255:0] key_in = '0;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic [127:0] block_in = '0;
    logic         key_ready, busy, done;
    logic [127:0] block_out;

    aes256_core uut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .start(start), .decrypt(decrypt), .block_in(block_in),
        .key_ready(key_ready), .busy(busy), .done(done), .block_out(block_out)
    );

    always #4 clk = ~clk;

    localparam logic [255:0] KEY_A = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] CT_A  = 128'h8ea2b7ca516745bfeafc49904b496089;
    localparam logic [127:0] CT_Z  = 128'hdc95c078a2408989ad48a21492842087;

    logic [127:0] exp_q [$];
    bit           chk_q [$];
    string        tag_q [$];
    logic [127:0] last_out;
    int           n_chk = 0;
    int           n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: scoreboard comparison on every result strobe
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R7 unexpected done", 128'(done), 128'(0));
            end else begin
                logic [127:0] e;
                bit           c;
                string        t;
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check(block_out == e, t, block_out, e);
                last_out = block_out;
            end
        end
    end

    task automatic load_key(input logic [255:0] k, input bit poke_start);
        bit saw_busy = 1'b0;
        @(negedge clk);
        key_load = 1'b1;
        key_in   = k;
        @(negedge clk);
        key_load = 1'b0;
        for (int e = 1; e <= 52; e++) begin
            if (poke_start && e == 10) start = 1'b1;
            if (poke_start && e == 11) start = 1'b0;
            @(negedge clk);
            if (busy) saw_busy = 1'b1;
            if (e == 51) check(key_ready == 1'b0, "R6 key_ready early", 128'(key_ready), 128'(0));
            if (e == 52) check(key_ready == 1'b1, "R6 key_ready at edge 52", 128'(key_ready), 128'(1));
        end
        if (poke_start) check(!saw_busy, "R5 start during expansion", 128'(saw_busy), 128'(0));
    endtask

    task automatic run_block(input logic [127:0] blk, input bit dec, input logic [127:0] expv,
                             input bit chk, input string tag, input bit poke_busy);
        @(negedge clk);
        start    = 1'b1;
        decrypt  = dec;
        block_in = blk;
        exp_q.push_back(expv);
        chk_q.push_back(chk);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after launch", 128'(busy), 128'(1));
        for (int e = 1; e <= 14; e++) begin
            if (poke_busy && e == 4) begin
                start    = 1'b1;
                decrypt  = ~dec;
                block_in = ~blk;
            end
            if (poke_busy && e == 5) start = 1'b0;
            @(negedge clk);
            if (e < 14 && done) check(1'b0, "R4 done early", 128'(e), 128'(14));
            if (e == 14) check(done == 1'b1, "R4 done at edge 14", 128'(done), 128'(1));
        end
        @(negedge clk);
        check(done == 1'b0, "R4 done single cycle", 128'(done), 128'(0));
        check(block_out == last_out, "R4 result held", block_out, last_out);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset values
        check(key_ready == 1'b0, "R8 key_ready", 128'(key_ready), 128'(0));
        check(busy == 1'b0, "R8 busy", 128'(busy), 128'(0));
        check(done == 1'b0, "R8 done", 128'(done), 128'(0));
        check(block_out == '0, "R8 block_out", block_out, '0);
        rst_n = 1'b1;

        // R5 start before any key
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R5 start without key", 128'(busy), 128'(0));

        load_key(KEY_A, 1'b1);
        run_block(PT_A, 1'b0, CT_A, 1'b1, "R1 known answer encrypt", 1'b0);
        run_block(CT_A, 1'b1, PT_A, 1'b1, "R2 known answer decrypt", 1'b0);
        // R7 start while busy
        run_block(PT_A, 1'b0, CT_A, 1'b1, "R7 block in flight unchanged", 1'b1);

        // R9 key replacement with all-zero key
        load_key('0, 1'b0);
        run_block('0, 1'b0, CT_Z, 1'b1, "R9 R1 zero-key encrypt", 1'b0);
        run_block(CT_Z, 1'b1, '0, 1'b1, "R9 R2 zero-key decrypt", 1'b0);

        // R3 round trips under the first key
        load_key(KEY_A, 1'b0);
        for (int n = 0; n < 8; n++) begin
            logic [127:0] p;
            logic [127:0] c;
            p = {$urandom, $urandom, $urandom, $urandom};
            run_block(p, 1'b0, '0, 1'b0, "R3 forward", 1'b0);
            c = last_out;
            check(c != p, "R3 ciphertext differs", c, p);
            run_block(c, 1'b1, p, 1'b1, "R3 round trip", 1'b0);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", 128'(exp_q.size()), 128'(0));
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule